// File: doc/BRIEF.md
# Quad Supply-Good Delay Sequencer

This block sequences four supplies and a system reset. Each of four channels receives a digital flag from an external comparator. The flag is high when that channel's supply is above its threshold. Once a flag has stayed high for a programmed number of timebase ticks, the channel's active-low good output is driven low. When all four good outputs are active, a second programmable tick delay runs, and then the active-low system reset is released.

If any monitored flag drops, the affected outputs return to their inactive level and the whole sequence starts again. A manual reset input is debounced in system clock cycles. Once it has been held high long enough, it forces all outputs inactive, and the delays restart when it is released.

A four-bit fault status register records which channel lost its supply while it was good. It resets to zero. Software arms it by writing ones, and it can be rewritten at any time without any enable latch. The timebase tick is nominally 1 ms. The delay tables are parameters, so a bench can scale time down.

Top module: `supply_seq_top`

## Requirements
- R1: While `mon_ok[i]` is low, `pg_n[i]` stays high, no matter how many ticks arrive.
- R2: A channel delay code selects a count of ticks: 0 selects `DLY_T0` (100), 1 selects `DLY_T1` (500), 2 selects `DLY_T2` (1000) and 3 selects `DLY_T3` (5000). `pg_n[i]` falls on the clock edge that samples the N-th tick after `mon_ok[i]` went and stayed high.
- R3: In `chan_dly_cfg`, channel i (0-based) takes its code from bits 2i+1:2i.
- R4: `sys_rst_n` is low until all four `pg_n` bits are low. It then rises on the edge that samples the N-th following tick, where N comes from the code in bits 3:2 of `rst_dly_cfg` through the same mapping as R2. The other bits of `rst_dly_cfg` are ignored.
- R5: If `mon_ok[i]` drops while channel i is still counting, its count restarts from zero.
- R6: If `man_rst` is sampled high on `MR_CYCLES` consecutive edges, the next edge drives every `pg_n` bit high and `sys_rst_n` low. After release, the full channel and reset delays run again.
- R7: A `man_rst` pulse shorter than `MR_CYCLES` cycles has no effect on any output.
- R8: If `mon_ok[i]` drops while `pg_n[i]` is low, then on the next edge `pg_n[i]` goes high and `sys_rst_n` goes low. When the flag returns, the channel delay and then the reset delay run again.
- R9: `flt_status` resets to 0. When `flt_wr_en` is high, `flt_wr_data` is loaded on the next edge with no other enable. A bit is never set other than by a write.
- R10: A supply loss as described in R8 clears `flt_status[i]` on the same edge that raises `pg_n[i]`. This clear wins over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse that delays count |
| mon_ok | input | 4 | Above-threshold flag per supply |
| man_rst | input | 1 | Manual reset request, active high |
| chan_dly_cfg | input | 8 | Four 2-bit channel delay codes |
| rst_dly_cfg | input | 8 | Reset delay code in bits 3:2 |
| flt_wr_en | input | 1 | Fault register write strobe |
| flt_wr_data | input | 4 | Fault register write value |
| pg_n | output | 4 | Per-channel supply-good output, active low |
| sys_rst_n | output | 1 | System reset, active low |
| flt_status | output | 4 | Fault status, 0 marks a failed channel |

## Verification
Delay results change on the clock edge that samples the completing tick. The bench raises each tick for a single cycle and samples at the following falling edge, so every check can record the exact tick index at which an output changed. A supply drop changes `pg_n`, `sys_rst_n` and `flt_status` on the first edge that sees it, and a fault write is visible after one edge. A manual reset acts one edge after the `MR_CYCLES`-th consecutive high sample. The bench therefore holds the pin for a counted number of cycles, both just below and above that count, before it samples the outputs.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;

    // Map a 2-bit delay code onto a tick count.
    function automatic int unsigned pick_ticks(
        input logic [1:0]  code,
        input int unsigned t0,
        input int unsigned t1,
        input int unsigned t2,
        input int unsigned t3
    );
        case (code)
            2'd0:    return t0;
            2'd1:    return t1;
            2'd2:    return t2;
            default: return t3;
        endcase
    endfunction

    function automatic int unsigned max4(
        input int unsigned a,
        input int unsigned b,
        input int unsigned c,
        input int unsigned d
    );
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/ssq_debounce.sv
module ssq_debounce #(
    parameter int unsigned HOLD_CYC = 625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic active
);
    localparam int unsigned CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } deb_t;

    deb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!raw) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != HOLD_V) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = (st_q.cnt == HOLD_V);

endmodule

// File: rtl/ssq_tick_timer.sv
module ssq_tick_timer
    import supply_seq_pkg::*;
#(
    parameter int unsigned DLY_T0 = 100,
    parameter int unsigned DLY_T1 = 500,
    parameter int unsigned DLY_T2 = 1000,
    parameter int unsigned DLY_T3 = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       run,
    input  logic [1:0] code,
    output logic       done
);
    localparam int unsigned MAXT = max4(DLY_T0, DLY_T1, DLY_T2, DLY_T3);
    localparam int unsigned CW   = $clog2(MAXT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } tmr_t;

    tmr_t          st_d, st_q;
    logic [CW-1:0] last_cnt;

    always_comb begin
        last_cnt = CW'(pick_ticks(code, DLY_T0, DLY_T1, DLY_T2, DLY_T3) - 1);
        st_d = st_q;
        if (!run) begin
            st_d = '0;
        end else if (!st_q.done && tick) begin
            if (st_q.cnt >= last_cnt) begin
                st_d.done = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;

endmodule

// File: rtl/ssq_fault_reg.sv
module ssq_fault_reg #(
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [NCH-1:0] wr_data,
    input  logic [NCH-1:0] fail,
    output logic [NCH-1:0] status
);
    typedef struct packed {
        logic [NCH-1:0] bits;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.bits = wr_data;
        st_d.bits = st_d.bits & ~fail;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.bits;

endmodule

// File: rtl/supply_seq_top.sv
module supply_seq_top #(
    parameter int unsigned NCH       = 4,
    parameter int unsigned DLY_T0    = 100,
    parameter int unsigned DLY_T1    = 500,
    parameter int unsigned DLY_T2    = 1000,
    parameter int unsigned DLY_T3    = 5000,
    parameter int unsigned MR_CYCLES = 625
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [NCH-1:0] mon_ok,
    input  logic           man_rst,
    input  logic [2*NCH-1:0] chan_dly_cfg,
    input  logic [7:0]     rst_dly_cfg,
    input  logic           flt_wr_en,
    input  logic [NCH-1:0] flt_wr_data,
    output logic [NCH-1:0] pg_n,
    output logic           sys_rst_n,
    output logic [NCH-1:0] flt_status
);
    localparam int unsigned RST_CODE_LSB = 2;

    logic           mr_act;
    logic [NCH-1:0] chan_good;
    logic [NCH-1:0] chan_fail;
    logic           rst_run;
    logic           rst_done;

    ssq_debounce #(.HOLD_CYC(MR_CYCLES)) mr_deb_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (man_rst),
        .active (mr_act)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        ssq_tick_timer #(
            .DLY_T0(DLY_T0), .DLY_T1(DLY_T1), .DLY_T2(DLY_T2), .DLY_T3(DLY_T3)
        ) chan_tmr_i (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .run   (mon_ok[g] & ~mr_act),
            .code  (chan_dly_cfg[2*g +: 2]),
            .done  (chan_good[g])
        );
        // Supply loss while the channel is reporting good.
        assign chan_fail[g] = chan_good[g] & ~mon_ok[g];
    end

    assign rst_run = (&chan_good) & (&mon_ok) & ~mr_act;

    ssq_tick_timer #(
        .DLY_T0(DLY_T0), .DLY_T1(DLY_T1), .DLY_T2(DLY_T2), .DLY_T3(DLY_T3)
    ) rst_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .run   (rst_run),
        .code  (rst_dly_cfg[RST_CODE_LSB +: 2]),
        .done  (rst_done)
    );

    ssq_fault_reg #(.NCH(NCH)) flt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (flt_wr_en),
        .wr_data (flt_wr_data),
        .fail    (chan_fail),
        .status  (flt_status)
    );

    assign pg_n      = ~chan_good;
    assign sys_rst_n = rst_done;

endmodule

// File: rtl/supply_seq_checker.sv
module supply_seq_checker #(
    parameter int unsigned NCH       = 4,
    parameter int unsigned MR_CYCLES = 625
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick,
    input logic [NCH-1:0] mon_ok,
    input logic           man_rst,
    input logic           flt_wr_en,
    input logic [NCH-1:0] pg_n,
    input logic           sys_rst_n,
    input logic [NCH-1:0] flt_status
);
    localparam int unsigned CW = $clog2(MR_CYCLES + 1);
    localparam logic [CW-1:0] MR_V = CW'(MR_CYCLES);

    logic [CW-1:0] hold_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            hold_cnt <= '0;
        else if (!man_rst)     hold_cnt <= '0;
        else if (hold_cnt != MR_V) hold_cnt <= hold_cnt + 1'b1;
    end

    AST_RST_NEEDS_ALL_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_n |-> (pg_n == '0)); // R4

    AST_MR_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_cnt == MR_V) |=> ((pg_n == '1) && !sys_rst_n)); // R6

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        AST_BELOW_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            !mon_ok[g] |=> pg_n[g]); // R1

        AST_GOOD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pg_n[g]) |-> $past(tick)); // R2

        AST_LOSS_CLEARS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
            (!pg_n[g] && !mon_ok[g]) |=> !flt_status[g]); // R10

        AST_FAULT_SET_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flt_status[g]) |-> $past(flt_wr_en)); // R9
    end

endmodule

bind supply_seq_top supply_seq_checker #(.NCH(NCH), .MR_CYCLES(MR_CYCLES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .mon_ok     (mon_ok),
    .man_rst    (man_rst),
    .flt_wr_en  (flt_wr_en),
    .pg_n       (pg_n),
    .sys_rst_n  (sys_rst_n),
    .flt_status (flt_status)
);

// File: tb/supply_seq_top_tb_top.sv
module supply_seq_top_tb_top;
    localparam int NCH = 4;
    localparam int T0 = 4, T1 = 6, T2 = 8, T3 = 10;
    localparam int MRC = 8;
    localparam int NVEC = 5;
    // {chan_dly_cfg, rst_dly_cfg}
    localparam logic [15:0] VEC [NVEC] = '{
        16'h00_00, 16'hE4_04, 16'h1B_F3, 16'hFF_08, 16'h72_0C
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [3:0] mon_ok = 4'h0;
    logic man_rst = 1'b0;
    logic [7:0] chan_dly_cfg = 8'h00;
    logic [7:0] rst_dly_cfg = 8'h00;
    logic flt_wr_en = 1'b0;
    logic [3:0] flt_wr_data = 4'h0;
    logic [3:0] pg_n;
    logic sys_rst_n;
    logic [3:0] flt_status;

    int n_chk = 0;
    int n_fail = 0;
    int first_t [NCH];
    int rel_t;

    always #4 clk = ~clk;

    supply_seq_top #(
        .NCH(NCH), .DLY_T0(T0), .DLY_T1(T1), .DLY_T2(T2), .DLY_T3(T3),
        .MR_CYCLES(MRC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mon_ok(mon_ok),
        .man_rst(man_rst), .chan_dly_cfg(chan_dly_cfg), .rst_dly_cfg(rst_dly_cfg),
        .flt_wr_en(flt_wr_en), .flt_wr_data(flt_wr_data),
        .pg_n(pg_n), .sys_rst_n(sys_rst_n), .flt_status(flt_status)
    );

    function automatic int dly_of(input logic [1:0] c);
        case (c)
            2'd0: return T0;
            2'd1: return T1;
            2'd2: return T2;
            default: return T3;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick_once();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick_once();
    endtask

    task automatic flt_write(input logic [3:0] v);
        @(negedge clk) begin flt_wr_en = 1'b1; flt_wr_data = v; end
        @(negedge clk) flt_wr_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=expired exp=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        cyc(3);
        // reset state
        chk("R9 reset fault", flt_status, 4'h0);
        chk("R1 reset pg_n", pg_n, 4'hF);
        chk("R4 reset sys_rst_n", sys_rst_n, 0);
        @(negedge clk) rst_n = 1'b1;

        // R1: ticks with all supplies below threshold
        ticks(12);
        chk("R1 held below", pg_n, 4'hF);
        chk("R4 held below", sys_rst_n, 0);

        // R2/R3/R4 vector walk
        for (int v = 0; v < NVEC; v++) begin
            mon_ok = 4'h0;
            cyc(2);
            chan_dly_cfg = VEC[v][15:8];
            rst_dly_cfg  = VEC[v][7:0];
            mon_ok = 4'hF;
            for (int c = 0; c < NCH; c++) first_t[c] = 0;
            rel_t = 0;
            for (int k = 1; k <= 24; k++) begin
                tick_once();
                for (int c = 0; c < NCH; c++)
                    if (!pg_n[c] && first_t[c] == 0) first_t[c] = k;
                if (sys_rst_n && rel_t == 0) rel_t = k;
            end
            begin
                int mx;
                mx = 0;
                for (int c = 0; c < NCH; c++) begin
                    int e;
                    e = dly_of(VEC[v][8+2*c +: 2]);
                    if (e > mx) mx = e;
                    chk("R2 R3 channel delay", first_t[c], e);
                end
                chk("R4 reset release", rel_t, mx + dly_of(VEC[v][3:2]));
            end
        end

        // R5: restart on drop during count (all codes 0 -> 4 ticks)
        mon_ok = 4'h0;
        cyc(2);
        chan_dly_cfg = 8'h00;
        rst_dly_cfg  = 8'h00;
        mon_ok = 4'hF;
        ticks(3);
        @(negedge clk) mon_ok = 4'hE;
        @(negedge clk) mon_ok = 4'hF;
        ticks(3);
        chk("R5 restarted channel", pg_n, 4'b0001);
        ticks(1);
        chk("R5 restarted done", pg_n, 4'h0);
        ticks(4);
        chk("R4 released", sys_rst_n, 1);

        // R9: write without enable latch
        flt_write(4'h5);
        chk("R9 write 5", flt_status, 4'h5);
        flt_write(4'hF);
        chk("R9 arm", flt_status, 4'hF);

        // R8/R10: supply loss after good
        @(negedge clk) mon_ok = 4'hB;
        @(negedge clk);
        chk("R8 pg_n lost", pg_n, 4'h4);
        chk("R8 reset reasserted", sys_rst_n, 0);
        chk("R10 fault bit", flt_status, 4'hB);
        mon_ok = 4'hF;
        ticks(4);
        chk("R8 resequenced pg", pg_n, 4'h0);
        chk("R8 reset still low", sys_rst_n, 0);
        ticks(4);
        chk("R8 reset released", sys_rst_n, 1);
        chk("R9 fault kept", flt_status, 4'hB);

        // R7: short manual reset pulse ignored
        @(negedge clk) man_rst = 1'b1;
        cyc(MRC - 1);
        man_rst = 1'b0;
        cyc(3);
        chk("R7 pg_n unchanged", pg_n, 4'h0);
        chk("R7 reset unchanged", sys_rst_n, 1);

        // R6: long manual reset
        @(negedge clk) man_rst = 1'b1;
        cyc(MRC + 3);
        chk("R6 pg_n forced", pg_n, 4'hF);
        chk("R6 reset forced", sys_rst_n, 0);
        ticks(6);
        chk("R6 held during press", pg_n, 4'hF);
        man_rst = 1'b0;
        cyc(1);
        ticks(3);
        chk("R6 delay rerun", pg_n, 4'hF);
        ticks(1);
        chk("R6 channels good", pg_n, 4'h0);
        ticks(3);
        chk("R6 reset delay rerun", sys_rst_n, 0);
        ticks(1);
        chk("R6 reset released", sys_rst_n, 1);
        chk("R9 fault untouched by manual reset", flt_status, 4'hB);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule